// File: doc/BRIEF.md
# USART-Style SPI Master Transfer Engine

This block is a full-duplex SPI master with a register-style front end. Software writes a byte to the data register. The byte waits in a one-entry transmit buffer until the shift register is free, and then it is shifted out on the serial data output. At the same time the serial data input is sampled into the receive path. The master makes the only serial clock, so every transfer is started by a write, including a transfer made only to receive data.

The serial clock period is 2×(divisor+1) system clocks. Clock polarity, clock phase and bit order can each be selected, so all four SPI modes are supported in both MSB-first and LSB-first order. Received bytes go into a two-entry queue backed by one holding stage. When all three places are occupied, a newly completed frame replaces the byte in the holding stage and raises an overrun flag.

Top module: `usart_spim_engine`

## Requirements
- R1: After reset the block shows `tx_empty`=1, `rx_ready`=0, `rx_overrun`=0, `sck`=0 and `mosi`=1.
- R2: While `tx_en`=0 there are no serial clock edges, `sck` rests at `cpol` and `mosi` is held at 1. A byte written in this state stays pending (`tx_empty`=0) and is sent once `tx_en` is set.
- R3: A data write (`wr_en` high for one cycle) is taken only while `tx_empty`=1 and is ignored otherwise. `tx_empty` goes low after a write is taken and goes high again once that byte has moved into the shift register.
- R4: Every `sck` half-period lasts `div`+1 system clocks, and a frame is 8 bits, which is 16 clock edges.
- R5: `cpol` sets the idle level of `sck`. With `cpha`=0 the first bit is on `mosi` before the first edge, data is sampled on the 1st, 3rd, … edges of a frame and changes on the 2nd, 4th, … edges. With `cpha`=1 data changes on the 1st, 3rd, … edges and is sampled on the 2nd, 4th, … edges.
- R6: With `lsb_first`=1, bit 0 goes first and the first bit received lands in bit 0. With `lsb_first`=0, bit 7 goes first and the first bit received lands in bit 7. This holds for both directions.
- R7: While `rx_en`=0, frames still run, but completed frames add nothing to the receive path and `rx_ready` stays 0.
- R8: `rx_ready` is 1 while at least one received byte is waiting. `rd_data` shows the oldest waiting byte. A one-cycle `rd_en` pulse while `rx_ready`=1 removes that byte, so bytes come out in arrival order.
- R9: The receive path holds up to three bytes. A frame that completes while all three are held replaces the third, most recent byte and sets `rx_overrun`. After four frames with no reads, the reads return bytes 1, 2 and 4.
- R10: `rx_overrun` is cleared by a read that removes a byte.
- R11: A byte accepted while a frame is in progress starts the next frame with no further write. The gap from the last edge of one frame to the first edge of the next is exactly `div`+2 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; clock generation and shifting run only while it is high |
| rx_en | input | 1 | Receiver enable; completed frames are stored only while it is high |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase: 0 samples on leading edges, 1 samples on trailing edges |
| lsb_first | input | 1 | 1 shifts bit 0 first, 0 shifts bit 7 first |
| div | input | 12 | Clock divisor; `sck` period is 2×(div+1) clocks |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Data register read strobe; removes the oldest received byte |
| rd_data | output | 8 | Oldest received byte |
| tx_empty | output | 1 | Transmit buffer can accept a byte |
| rx_ready | output | 1 | At least one received byte is waiting |
| rx_overrun | output | 1 | A received byte was lost |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data output |
| miso | input | 1 | Serial data input |

## Verification
The assertions check on every cycle:
- the receive-occupancy bound;
- that the holding stage is used only when the queue is full;
- that `rx_overrun` rises only with a completed frame and falls only on a read;
- that `tx_empty` returns after a load;
- that the clock idles while the transmitter is disabled;
- that completion pulses and divider ticks are single-cycle.

The bench scenarios, run against a bench-side SPI slave model, are needed for the rest:
- the correct bit values on both data lines in every mode and bit order;
- the measured half-period and inter-frame gap;
- the order of the bytes kept after an overflow;
- the refusal of a write while the buffer is full.

// File: rtl/uspim_pkg.sv
package uspim_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } uspim_mode_t;

endpackage

// File: rtl/uspim_clkdiv.sv
module uspim_clkdiv #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == div) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == div);

  // half-period ticks are separated by div+1 clocks
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0) |=> (!tick || div == '0)); // R4

endmodule

// File: rtl/uspim_shifter.sv
module uspim_shifter
  import uspim_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tx_en,
  input  uspim_mode_t           mode,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] start_data,
  input  logic                  tick,
  input  logic                  miso,
  output logic                  busy,
  output logic                  sck,
  output logic                  mosi,
  output logic                  done,
  output logic [FRAME_BITS-1:0] rx_byte
);

  localparam int EDGES = 2 * FRAME_BITS;
  localparam int HW    = $clog2(EDGES);
  localparam logic [HW-1:0] LAST_EDGE = HW'(EDGES - 1);

  logic                  busy_q;
  logic                  sck_q;
  logic                  done_q;
  logic [HW-1:0]         edge_idx;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [FRAME_BITS-1:0] rx_sh;
  logic [FRAME_BITS-1:0] rx_q;

  logic                  samp_edge;
  logic                  shift_edge;
  logic                  out_bit;
  logic [FRAME_BITS-1:0] tx_next;
  logic [FRAME_BITS-1:0] rx_next;
  logic [FRAME_BITS-1:0] rx_cap;

  // even edge index = leading edge; phase picks sample vs. change
  assign samp_edge  = (edge_idx[0] == mode.cpha);
  assign shift_edge = (edge_idx[0] != mode.cpha) && (edge_idx != '0) && (edge_idx != LAST_EDGE);

  always_comb begin
    if (mode.lsb_first) begin
      out_bit = tx_sh[0];
      tx_next = {1'b0, tx_sh[FRAME_BITS-1:1]};
      rx_next = {miso, rx_sh[FRAME_BITS-1:1]};
    end else begin
      out_bit = tx_sh[FRAME_BITS-1];
      tx_next = {tx_sh[FRAME_BITS-2:0], 1'b0};
      rx_next = {rx_sh[FRAME_BITS-2:0], miso};
    end
    rx_cap = samp_edge ? rx_next : rx_sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      sck_q    <= 1'b0;
      done_q   <= 1'b0;
      edge_idx <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!tx_en) begin
        busy_q   <= 1'b0;
        edge_idx <= '0;
        sck_q    <= mode.cpol;
      end else if (!busy_q) begin
        sck_q <= mode.cpol;
        if (start) begin
          busy_q   <= 1'b1;
          edge_idx <= '0;
          tx_sh    <= start_data;
        end
      end else if (tick) begin
        sck_q <= ~sck_q;
        rx_sh <= rx_cap;
        if (shift_edge) begin
          tx_sh <= tx_next;
        end
        if (edge_idx == LAST_EDGE) begin
          busy_q   <= 1'b0;
          edge_idx <= '0;
          done_q   <= 1'b1;
          rx_q     <= rx_cap;
        end else begin
          edge_idx <= edge_idx + 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign sck     = sck_q;
  assign mosi    = tx_en ? out_bit : 1'b1;
  assign done    = done_q;
  assign rx_byte = rx_q;

  AST_SCK_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (sck == $past(mode.cpol))); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4

  AST_BUSY_NEEDS_TX: assert property (@(posedge clk) disable iff (rst)
    busy |-> $past(tx_en)); // R2

endmodule

// File: rtl/uspim_rxq.sv
module uspim_rxq #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] in_data,
  input  logic         rd,
  output logic [W-1:0] out_data,
  output logic         ready,
  output logic         overrun
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_inc, rptr_inc;
  logic [CW-1:0] count;
  logic [W-1:0]  hold;
  logic          hold_v;
  logic          ovr_q;

  logic          pop;
  logic          wr_fifo;
  logic [W-1:0]  wr_val;
  logic [W-1:0]  hold_n;
  logic          hold_vn;
  logic          lost;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wptr_inc = wptr + 1'b1;
      assign rptr_inc = rptr + 1'b1;
    end else begin : g_wrap
      assign wptr_inc = (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
      assign rptr_inc = (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
    end
  endgenerate

  assign pop = rd && (count != '0);

  always_comb begin
    wr_fifo = 1'b0;
    wr_val  = in_data;
    hold_n  = hold;
    hold_vn = hold_v;
    lost    = 1'b0;
    if (pop && hold_v) begin
      wr_fifo = 1'b1;
      wr_val  = hold;
      hold_vn = push;
      if (push) begin
        hold_n = in_data;
      end
    end else if (push) begin
      if (hold_v) begin
        hold_n = in_data;
        lost   = 1'b1;
      end else if (count == FULL_CNT && !pop) begin
        hold_n  = in_data;
        hold_vn = 1'b1;
      end else begin
        wr_fifo = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fifo) begin
      mem[wptr] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      count  <= '0;
      hold   <= '0;
      hold_v <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_fifo) wptr <= wptr_inc;
      if (pop)     rptr <= rptr_inc;
      count  <= count + CW'(wr_fifo) - CW'(pop);
      hold   <= hold_n;
      hold_v <= hold_vn;
      if (lost) begin
        ovr_q <= 1'b1;
      end else if (pop) begin
        ovr_q <= 1'b0;
      end
    end
  end

  assign out_data = mem[rptr];
  assign ready    = (count != '0);
  assign overrun  = ovr_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT); // R9

  AST_HOLD_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    hold_v |-> (count == FULL_CNT)); // R9

  AST_OVR_RISE_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(push)); // R9

  AST_OVR_FALL_ON_READ: assert property (@(posedge clk) disable iff (rst)
    $fell(overrun) |-> $past(rd)); // R10

endmodule

// File: rtl/usart_spim_engine.sv
module usart_spim_engine
  import uspim_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int DIV_W      = 12,
  parameter int RXQ_DEPTH  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tx_en,
  input  logic                  rx_en,
  input  logic                  cpol,
  input  logic                  cpha,
  input  logic                  lsb_first,
  input  logic [DIV_W-1:0]      div,
  input  logic                  wr_en,
  input  logic [FRAME_BITS-1:0] wr_data,
  input  logic                  rd_en,
  output logic [FRAME_BITS-1:0] rd_data,
  output logic                  tx_empty,
  output logic                  rx_ready,
  output logic                  rx_overrun,
  output logic                  sck,
  output logic                  mosi,
  input  logic                  miso
);

  uspim_mode_t           mode;
  logic                  txb_v;
  logic [FRAME_BITS-1:0] txb;
  logic                  busy;
  logic                  start;
  logic                  tick;
  logic                  done;
  logic [FRAME_BITS-1:0] rx_byte;

  assign mode = '{cpol: cpol, cpha: cpha, lsb_first: lsb_first};

  // transmit buffer: one entry, refilled only while empty
  assign start = tx_en && !busy && txb_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      txb_v <= 1'b0;
      txb   <= '0;
    end else begin
      if (start) begin
        txb_v <= 1'b0;
      end
      if (wr_en && !txb_v) begin
        txb_v <= 1'b1;
        txb   <= wr_data;
      end
    end
  end

  assign tx_empty = !txb_v;

  uspim_clkdiv #(
    .DIV_W (DIV_W)
  ) u_clkdiv (
    .clk  (clk),
    .rst  (rst),
    .run  (busy && tx_en),
    .div  (div),
    .tick (tick)
  );

  uspim_shifter #(
    .FRAME_BITS (FRAME_BITS)
  ) u_shifter (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .mode       (mode),
    .start      (start),
    .start_data (txb),
    .tick       (tick),
    .miso       (miso),
    .busy       (busy),
    .sck        (sck),
    .mosi       (mosi),
    .done       (done),
    .rx_byte    (rx_byte)
  );

  uspim_rxq #(
    .W     (FRAME_BITS),
    .DEPTH (RXQ_DEPTH)
  ) u_rxq (
    .clk      (clk),
    .rst      (rst),
    .push     (done && rx_en),
    .in_data  (rx_byte),
    .rd       (rd_en),
    .out_data (rd_data),
    .ready    (rx_ready),
    .overrun  (rx_overrun)
  );

  AST_LOAD_FREES_BUFFER: assert property (@(posedge clk) disable iff (rst)
    start |=> tx_empty); // R3

  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!tx_empty && !start) |=> (!tx_empty && $stable(txb))); // R3

  AST_NO_STORE_RX_OFF: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !rx_ready) |=> !rx_ready); // R7

endmodule

// File: tb/tb_usart_spim_engine.sv
`timescale 1ns/1ps
module tb_usart_spim_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 1'b0, rx_en = 1'b0, cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
  logic [11:0] div = 12'd0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        tx_empty, rx_ready, rx_overrun, sck, mosi;
  logic        miso_r = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  usart_spim_engine dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .cpol(cpol), .cpha(cpha),
    .lsb_first(lsb_first), .div(div), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .tx_empty(tx_empty), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
    .sck(sck), .mosi(mosi), .miso(miso_r)
  );

  // ---------------- bench-side SPI slave model ----------------
  logic [7:0] s_tx [8];
  logic [7:0] cap  [8];
  logic [7:0] wb   [8];
  logic [7:0] m_rx = 8'h00;
  int gen = 0, last_gen = 0;
  int e = 0, idx = 0, ncap = 0, nedges = 0, since = 0;
  int hp_min = 1 << 30, hp_max = 0, gap_max = 0;
  logic prev_sck = 1'b0;

  function automatic logic pick(input logic [7:0] b, input int k, input logic lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  function automatic int bpos(input int k, input logic lsb);
    return lsb ? k : 7 - k;
  endfunction

  always @(negedge clk) begin
    if (gen != last_gen) begin
      last_gen = gen;
      e = 0; idx = 0; ncap = 0; nedges = 0; since = 0;
      hp_min = 1 << 30; hp_max = 0; gap_max = 0;
      prev_sck = sck;
      miso_r = cpha ? 1'b0 : pick(s_tx[0], 0, lsb_first);
    end else begin
      since = since + 1;
      if (sck != prev_sck) begin
        prev_sck = sck;
        nedges = nedges + 1;
        if (e == 0) begin
          if (ncap > 0 && since > gap_max) gap_max = since;
        end else begin
          if (since < hp_min) hp_min = since;
          if (since > hp_max) hp_max = since;
        end
        since = 0;
        if ((e % 2) == int'(cpha)) begin
          m_rx[bpos(e / 2, lsb_first)] = mosi;
        end else if (cpha) begin
          miso_r = pick(s_tx[idx], e / 2, lsb_first);
        end else if (e != 15) begin
          miso_r = pick(s_tx[idx], (e + 1) / 2, lsb_first);
        end
        if (e == 15) begin
          cap[idx] = m_rx;
          idx = idx + 1;
          ncap = ncap + 1;
          e = 0;
          if (!cpha && idx < 8) miso_r = pick(s_tx[idx], 0, lsb_first);
        end else begin
          e = e + 1;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    while (!tx_empty) @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic read_chk(input logic [7:0] exp, input string tag);
    check(rx_ready == 1'b1, tag, rx_ready, 1);
    check(rd_data == exp, tag, rd_data, exp);
    rd_en = 1'b1;
    cyc(1);
    rd_en = 1'b0;
  endtask

  task automatic setup(input int dv, input logic pol, input logic pha, input logic lsb, input logic rxe);
    tx_en = 1'b0;
    cyc(1);
    div = 12'(dv); cpol = pol; cpha = pha; lsb_first = lsb; rx_en = rxe;
    for (int i = 0; i < 8; i++) begin
      s_tx[i] = 8'($urandom);
      wb[i]   = 8'($urandom);
    end
    cyc(3);
    gen++;
    cyc(2);
  endtask

  function automatic int frame_wait(input int n, input int dv);
    return n * (16 * (dv + 1) + 4) + 20;
  endfunction

  task automatic xfer(input int n, input int dv, input logic pol, input logic pha,
                      input logic lsb, input logic rxe, input string tag);
    setup(dv, pol, pha, lsb, rxe);
    tx_en = 1'b1;
    for (int i = 0; i < n; i++) put(wb[i]);
    cyc(frame_wait(n, dv));
    check(ncap == n, tag, ncap, n);
    for (int i = 0; i < n; i++) check(cap[i] == wb[i], tag, cap[i], wb[i]);
    check(hp_min == dv + 1 && hp_max == dv + 1, "R4 half-period", hp_max, dv + 1);
    if (n >= 2) check(gap_max == dv + 2, "R11 back-to-back gap", gap_max, dv + 2);
    if (!rxe) begin
      check(rx_ready == 1'b0, "R7 rx disabled", rx_ready, 0);
    end else if (n <= 3) begin
      for (int i = 0; i < n; i++) read_chk(s_tx[i], tag);
      check(rx_ready == 1'b0, "R8 drained", rx_ready, 0);
    end else begin
      check(rx_overrun == 1'b1, "R9 overrun set", rx_overrun, 1);
      read_chk(s_tx[0], "R9 first kept");
      check(rx_overrun == 1'b0, "R10 overrun cleared", rx_overrun, 0);
      read_chk(s_tx[1], "R9 second kept");
      read_chk(s_tx[3], "R9 newest replaces third");
      check(rx_ready == 1'b0, "R8 drained", rx_ready, 0);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 8; i++) begin
      s_tx[i] = 8'h00; cap[i] = 8'h00; wb[i] = 8'h00;
    end
    repeat (4) @(posedge clk);
    rst = 1'b0;
    cyc(1);

    // R1 reset state
    check(tx_empty == 1'b1,   "R1 tx_empty", tx_empty, 1);
    check(rx_ready == 1'b0,   "R1 rx_ready", rx_ready, 0);
    check(rx_overrun == 1'b0, "R1 rx_overrun", rx_overrun, 0);
    check(sck == 1'b0,        "R1 sck", sck, 0);
    check(mosi == 1'b1,       "R1 mosi", mosi, 1);

    // R2 transmitter disabled: byte held, no clock, idle levels
    setup(2, 1'b1, 1'b0, 1'b0, 1'b1);
    put(8'hA5);
    cyc(200);
    check(tx_empty == 1'b0, "R2 pending kept", tx_empty, 0);
    check(nedges == 0,      "R2 no sck edges", nedges, 0);
    check(sck == 1'b1,      "R2 sck at cpol", sck, 1);
    check(mosi == 1'b1,     "R2 mosi idle", mosi, 1);
    tx_en = 1'b1;
    cyc(frame_wait(1, 2));
    check(ncap == 1,        "R2 sent after enable", ncap, 1);
    check(cap[0] == 8'hA5,  "R2 byte out", cap[0], 8'hA5);
    read_chk(s_tx[0], "R2 byte in");

    // R3 write refused while buffer full
    setup(3, 1'b0, 1'b0, 1'b0, 1'b1);
    tx_en = 1'b1;
    put(8'h3C);
    check(tx_empty == 1'b0, "R3 empty falls on write", tx_empty, 0);
    cyc(2);
    check(tx_empty == 1'b1, "R3 empty rises on load", tx_empty, 1);
    put(8'hC3);
    check(tx_empty == 1'b0, "R3 buffer full", tx_empty, 0);
    wr_en = 1'b1; wr_data = 8'h5A;
    cyc(1);
    wr_en = 1'b0;
    cyc(frame_wait(3, 3));
    check(ncap == 2,        "R3 ignored write not sent", ncap, 2);
    check(cap[0] == 8'h3C,  "R3 first byte", cap[0], 8'h3C);
    check(cap[1] == 8'hC3,  "R3 second byte", cap[1], 8'hC3);
    read_chk(s_tx[0], "R8 order first");
    read_chk(s_tx[1], "R8 order second");
    check(rx_ready == 1'b0, "R3 only two received", rx_ready, 0);

    // R5 / R6: every mode in both bit orders
    for (int m = 0; m < 8; m++) begin
      xfer(2, 1, m[0], m[1], m[2], 1'b1, "R5/R6 mode sweep");
    end

    // R9 / R10 overflow with four frames and no reads
    xfer(4, 0, 1'b0, 1'b1, 1'b0, 1'b1, "R9 four frames");

    // R7 receiver disabled
    xfer(2, 2, 1'b1, 1'b1, 1'b1, 1'b0, "R7 frames run");

    // constrained random scenarios
    for (int k = 0; k < 12; k++) begin
      int n  = 1 + int'($urandom % 3);
      int dv = int'($urandom % 5);
      int md = int'($urandom % 8);
      xfer(n, dv, md[0], md[1], md[2], 1'b1, "R5/R6/R8 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule